// File: doc/BRIEF.md
# Selective Bit-Plane Transposer

The block turns a group of numeric elements into bit-planes, so that an error-coding stage can protect only the bit positions that matter. Elements arrive one per cycle, least-indexed first. A group holds `N_ELEM` elements of `N_BITS` bits each. Once a group is complete, its planes leave one per cycle as `N_ELEM`-bit words. Bit j of the word for plane i is bit i of the j-th element of the group.

A runtime mask picks which planes go out on the protected stream. The remaining planes go out on a separate unprotected stream. Typical masks pick the exponent field of a floating-point format: bits 14..10 for half precision, or bits 30..23 for single precision when `N_BITS` is 32. Sign and mantissa planes are left unprotected. The count of selected planes is given on `sel_count`, so the protected fraction is `sel_count / N_BITS`.

Two group buffers let a new group be written while the previous one drains. A separate reverse path takes planes tagged with their index, in any order, and rebuilds the elements. This lets a consumer round-trip the data.

All streaming interfaces use valid/ready:
- A transfer happens on a rising clock edge where both valid and ready are high.
- A source holds its data and tag stable while valid is high and ready is low.
- Valid never waits on ready.
- `in_ready` drops only when both group buffers hold complete groups that have not drained.
- `pin_ready` drops while the rebuilt elements are being emitted.

Top module: `bpt_transposer`

## Requirements
- R1: While reset is active and right after it, `in_ready` and `pin_ready` are 1, and `prot_valid`, `unp_valid` and `eout_valid` are 0.
- R2: For a group whose elements e0..e(M-1) were accepted in that order, the word emitted for plane i has bit j equal to bit i of ej.
- R3: Plane i leaves on the protected port (`prot_*`) when bit i of the group's mask is 1, and on the unprotected port (`unp_*`) when it is 0. The tag output carries i.
- R4: Each group yields exactly `N_BITS` plane transfers. All selected planes come first in ascending index, then all unselected planes in ascending index. At most one of the two output valids is high in any cycle.
- R5: The mask is sampled in the cycle that the group's first element is accepted. Changes to `prot_mask` after that cycle do not affect the routing of that group.
- R6: While either output valid is high, `sel_count` equals the number of ones in the mask of the group being drained.
- R7: While an output valid is high and its ready is low, the valid, word and tag on that port stay unchanged in the next cycle.
- R8: While one group drains, intake of the next group continues. `in_ready` goes low only when two complete groups are waiting, and it returns high when the older group's last plane is taken.
- R9: The reverse path accepts planes on `pin_*` in any order, keyed by `pin_plane`. Once all `N_BITS` distinct planes have been received, it emits `N_ELEM` elements in index order on `eout_*`, with element j bit i equal to bit j of plane i. `pin_ready` stays low until the last element is taken.
- R10: While `eout_valid` is high and `eout_ready` is low, `eout_elem` and `eout_valid` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_mask | input | N_BITS | Plane selection mask, sampled per group |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Element accepted when high |
| in_elem | input | N_BITS | Element value |
| prot_valid | output | 1 | Protected plane offered |
| prot_ready | input | 1 | Protected consumer ready |
| prot_word | output | N_ELEM | Protected plane bits |
| prot_plane | output | $clog2(N_BITS) | Protected plane index |
| unp_valid | output | 1 | Unprotected plane offered |
| unp_ready | input | 1 | Unprotected consumer ready |
| unp_word | output | N_ELEM | Unprotected plane bits |
| unp_plane | output | $clog2(N_BITS) | Unprotected plane index |
| sel_count | output | $clog2(N_BITS+1) | Selected plane count of draining group |
| pin_valid | input | 1 | Reverse-path plane offered |
| pin_ready | output | 1 | Reverse-path plane accepted when high |
| pin_word | input | N_ELEM | Reverse-path plane bits |
| pin_plane | input | $clog2(N_BITS) | Reverse-path plane index |
| eout_valid | output | 1 | Rebuilt element offered |
| eout_ready | input | 1 | Rebuilt element consumer ready |
| eout_elem | output | N_BITS | Rebuilt element value |

## Verification
The overlap that matters is the intake of a new group coinciding with the drain of the previous one. The last plane of one buffer can be taken in the same cycle that the final element of the other buffer arrives, so one buffer is released while the other is filled.

The bench provokes this in three ways:
- It streams groups back to back with both consumers always ready.
- It stalls both consumers until two groups are waiting and then releases them.
- It throttles the consumers pseudo-randomly.

A scoreboard built from the elements and the mask seen at each group's first element judges every plane's port, tag, order, bits and count. Alongside, the bench checks that `in_ready` falls only while two groups are pending.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  localparam int DEF_N_BITS = 16;
  localparam int DEF_N_ELEM = 32;

  // Which output stream a plane is routed to
  typedef enum logic {
    ROUTE_PROT = 1'b0,
    ROUTE_UNP  = 1'b1
  } plane_route_e;
endpackage

// File: rtl/bpt_plane_store.sv
module bpt_plane_store #(
  parameter int N_BITS = bpt_pkg::DEF_N_BITS,
  parameter int N_ELEM = bpt_pkg::DEF_N_ELEM,
  localparam int PW = $clog2(N_BITS),
  localparam int EW = $clog2(N_ELEM)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_buf,
  input  logic [EW-1:0]     wr_idx,
  input  logic [N_BITS-1:0] wr_elem,
  input  logic              rd_buf,
  input  logic [PW-1:0]     rd_plane,
  output logic [N_ELEM-1:0] rd_word
);
  // Storage is plane-major: each row is one plane of one buffer
  logic [N_ELEM-1:0] mem [2][N_BITS];

  for (genvar i = 0; i < N_BITS; i++) begin : g_plane_wr
    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_buf][i][wr_idx] <= wr_elem[i];
    end
  end

  assign rd_word = mem[rd_buf][rd_plane];
endmodule

// File: rtl/bpt_drain_seq.sv
module bpt_drain_seq #(
  parameter int N_BITS = bpt_pkg::DEF_N_BITS,
  localparam int PW = $clog2(N_BITS),
  localparam int SW = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [N_BITS-1:0] mask,
  input  logic              hs,
  output logic [PW-1:0]     plane_o,
  output bpt_pkg::plane_route_e route_o,
  output logic              last_o
);
  // Walk a virtual sequence of 2*N_BITS slots:
  // slots 0..N-1 hold the selected pass, slots N..2N-1 the unselected pass.
  logic [SW-1:0] pos;
  logic [PW-1:0] cnt;
  logic [SW-1:0] next_pos;

  always_comb begin
    plane_o  = '0;
    route_o  = bpt_pkg::ROUTE_PROT;
    next_pos = '0;
    for (int q = 2 * N_BITS - 1; q >= 0; q--) begin
      if (q >= int'(pos) && (mask[q % N_BITS] != (q >= N_BITS))) begin
        plane_o  = PW'(q % N_BITS);
        route_o  = (q >= N_BITS) ? bpt_pkg::ROUTE_UNP : bpt_pkg::ROUTE_PROT;
        next_pos = SW'(q + 1);
      end
    end
  end

  assign last_o = active && (cnt == PW'(N_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      cnt <= '0;
    end else if (active && hs) begin
      if (last_o) begin
        pos <= '0;
        cnt <= '0;
      end else begin
        pos <= next_pos;
        cnt <= cnt + PW'(1);
      end
    end
  end
endmodule

// File: rtl/bpt_rebuild.sv
module bpt_rebuild #(
  parameter int N_BITS = bpt_pkg::DEF_N_BITS,
  parameter int N_ELEM = bpt_pkg::DEF_N_ELEM,
  localparam int PW = $clog2(N_BITS),
  localparam int EW = $clog2(N_ELEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_valid,
  output logic              pin_ready,
  input  logic [N_ELEM-1:0] pin_word,
  input  logic [PW-1:0]     pin_plane,
  output logic              eout_valid,
  input  logic              eout_ready,
  output logic [N_BITS-1:0] eout_elem
);
  logic [N_ELEM-1:0] pbuf [N_BITS];
  logic [N_BITS-1:0] got;
  logic [N_BITS-1:0] got_nx;
  logic              emitting;
  logic [EW-1:0]     k;

  assign pin_ready  = !emitting;
  assign eout_valid = emitting;
  assign got_nx     = got | (N_BITS'(1) << pin_plane);

  for (genvar i = 0; i < N_BITS; i++) begin : g_elem_bit
    assign eout_elem[i] = pbuf[i][k];
  end

  always_ff @(posedge clk) begin
    if (pin_valid && pin_ready) pbuf[pin_plane] <= pin_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got      <= '0;
      emitting <= 1'b0;
      k        <= '0;
    end else if (emitting) begin
      if (eout_ready) begin
        if (k == EW'(N_ELEM - 1)) begin
          k        <= '0;
          emitting <= 1'b0;
          got      <= '0;
        end else begin
          k <= k + EW'(1);
        end
      end
    end else if (pin_valid) begin
      got <= got_nx;
      if (&got_nx) emitting <= 1'b1;
    end
  end
endmodule

// File: rtl/bpt_transposer.sv
module bpt_transposer #(
  parameter int N_BITS = bpt_pkg::DEF_N_BITS,
  parameter int N_ELEM = bpt_pkg::DEF_N_ELEM,
  localparam int PW = $clog2(N_BITS),
  localparam int EW = $clog2(N_ELEM),
  localparam int CW = $clog2(N_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] prot_mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N_BITS-1:0] in_elem,
  output logic              prot_valid,
  input  logic              prot_ready,
  output logic [N_ELEM-1:0] prot_word,
  output logic [PW-1:0]     prot_plane,
  output logic              unp_valid,
  input  logic              unp_ready,
  output logic [N_ELEM-1:0] unp_word,
  output logic [PW-1:0]     unp_plane,
  output logic [CW-1:0]     sel_count,
  input  logic              pin_valid,
  output logic              pin_ready,
  input  logic [N_ELEM-1:0] pin_word,
  input  logic [PW-1:0]     pin_plane,
  output logic              eout_valid,
  input  logic              eout_ready,
  output logic [N_BITS-1:0] eout_elem
);
  logic              wr_buf, rd_buf;
  logic [EW-1:0]     wr_idx;
  logic [1:0]        full, full_nx;
  logic [N_BITS-1:0] gmask [2];
  logic              in_fire, grp_filled, grp_done, hs, drain_act;
  logic [PW-1:0]     cur_plane;
  logic [N_ELEM-1:0] cur_word;
  bpt_pkg::plane_route_e cur_route;

  assign in_ready   = !full[wr_buf];
  assign in_fire    = in_valid && in_ready;
  assign grp_filled = in_fire && (wr_idx == EW'(N_ELEM - 1));
  assign drain_act  = full[rd_buf];

  assign prot_valid = drain_act && (cur_route == bpt_pkg::ROUTE_PROT);
  assign unp_valid  = drain_act && (cur_route == bpt_pkg::ROUTE_UNP);
  assign prot_word  = cur_word;
  assign unp_word   = cur_word;
  assign prot_plane = cur_plane;
  assign unp_plane  = cur_plane;
  assign sel_count  = CW'($countones(gmask[rd_buf]));
  assign hs         = (prot_valid && prot_ready) || (unp_valid && unp_ready);

  logic last_plane;
  assign grp_done = hs && last_plane;

  always_comb begin
    full_nx = full;
    if (grp_filled) full_nx[wr_buf] = 1'b1;
    if (grp_done)   full_nx[rd_buf] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_buf   <= 1'b0;
      rd_buf   <= 1'b0;
      wr_idx   <= '0;
      full     <= '0;
      gmask[0] <= '0;
      gmask[1] <= '0;
    end else begin
      if (in_fire) begin
        if (wr_idx == '0) gmask[wr_buf] <= prot_mask;
        if (grp_filled) begin
          wr_idx <= '0;
          wr_buf <= ~wr_buf;
        end else begin
          wr_idx <= wr_idx + EW'(1);
        end
      end
      if (grp_done) rd_buf <= ~rd_buf;
      full <= full_nx;
    end
  end

  bpt_plane_store #(.N_BITS(N_BITS), .N_ELEM(N_ELEM)) u_store (
    .clk      (clk),
    .wr_en    (in_fire),
    .wr_buf   (wr_buf),
    .wr_idx   (wr_idx),
    .wr_elem  (in_elem),
    .rd_buf   (rd_buf),
    .rd_plane (cur_plane),
    .rd_word  (cur_word)
  );

  bpt_drain_seq #(.N_BITS(N_BITS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (drain_act),
    .mask    (gmask[rd_buf]),
    .hs      (hs),
    .plane_o (cur_plane),
    .route_o (cur_route),
    .last_o  (last_plane)
  );

  bpt_rebuild #(.N_BITS(N_BITS), .N_ELEM(N_ELEM)) u_rebuild (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_valid  (pin_valid),
    .pin_ready  (pin_ready),
    .pin_word   (pin_word),
    .pin_plane  (pin_plane),
    .eout_valid (eout_valid),
    .eout_ready (eout_ready),
    .eout_elem  (eout_elem)
  );
endmodule

// File: rtl/bpt_transposer_chk.sv
module bpt_transposer_chk #(
  parameter int N_BITS = bpt_pkg::DEF_N_BITS,
  parameter int N_ELEM = bpt_pkg::DEF_N_ELEM,
  localparam int PW = $clog2(N_BITS),
  localparam int CW = $clog2(N_BITS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              prot_valid,
  input logic              prot_ready,
  input logic [N_ELEM-1:0] prot_word,
  input logic [PW-1:0]     prot_plane,
  input logic              unp_valid,
  input logic              unp_ready,
  input logic [N_ELEM-1:0] unp_word,
  input logic [PW-1:0]     unp_plane,
  input logic [CW-1:0]     sel_count,
  input logic              pin_valid,
  input logic              pin_ready,
  input logic              eout_valid,
  input logic              eout_ready,
  input logic [N_BITS-1:0] eout_elem
);
  a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(prot_valid && unp_valid));

  a_r6_prot_count: assert property (@(posedge clk) disable iff (!rst_n)
    prot_valid |-> (sel_count != '0));

  a_r6_unp_count: assert property (@(posedge clk) disable iff (!rst_n)
    unp_valid |-> (sel_count != CW'(N_BITS)));

  a_r7_prot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_valid && !prot_ready) |=> (prot_valid && $stable(prot_word) && $stable(prot_plane)));

  a_r7_unp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (unp_valid && !unp_ready) |=> (unp_valid && $stable(unp_word) && $stable(unp_plane)));

  a_r8_stall_has_drain: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (prot_valid || unp_valid));

  a_r9_emit_after_plane: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eout_valid) |-> $past(pin_valid && pin_ready));

  a_r10_eout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eout_valid && !eout_ready) |=> (eout_valid && $stable(eout_elem)));
endmodule

bind bpt_transposer bpt_transposer_chk #(.N_BITS(N_BITS), .N_ELEM(N_ELEM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .prot_valid (prot_valid),
  .prot_ready (prot_ready),
  .prot_word  (prot_word),
  .prot_plane (prot_plane),
  .unp_valid  (unp_valid),
  .unp_ready  (unp_ready),
  .unp_word   (unp_word),
  .unp_plane  (unp_plane),
  .sel_count  (sel_count),
  .pin_valid  (pin_valid),
  .pin_ready  (pin_ready),
  .eout_valid (eout_valid),
  .eout_ready (eout_ready),
  .eout_elem  (eout_elem)
);

// File: tb/bpt_transposer_bench.sv
`timescale 1ns/1ps
module bpt_transposer_bench;
  localparam int N  = 16;
  localparam int M  = 32;
  localparam int PW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]  prot_mask = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  in_elem = '0;
  logic          prot_valid, unp_valid;
  logic          prot_ready = 1'b0, unp_ready = 1'b0;
  logic [M-1:0]  prot_word, unp_word;
  logic [PW-1:0] prot_plane, unp_plane;
  logic [CW-1:0] sel_count;
  logic          pin_valid = 1'b0;
  logic          pin_ready;
  logic [M-1:0]  pin_word = '0;
  logic [PW-1:0] pin_plane = '0;
  logic          eout_valid;
  logic          eout_ready = 1'b0;
  logic [N-1:0]  eout_elem;

  bpt_transposer #(.N_BITS(N), .N_ELEM(M)) u_bpt_transposer (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int rdy_mode = 0; // 0 always ready, 1 random, 2 held low

  typedef struct { bit unp; int plane; logic [M-1:0] word; int cnt; } pitem_t;
  pitem_t      pq[$];
  logic [N-1:0] eq[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: push expected planes, then feed the elements
  task automatic send_group(input logic [N-1:0] m0, input bit swap_mask, input int seed);
    logic [N-1:0] el [M];
    pitem_t it;
    for (int j = 0; j < M; j++) el[j] = N'($urandom(seed + j)) ^ N'(j * 977);
    for (int pass = 0; pass < 2; pass++)
      for (int i = 0; i < N; i++)
        if (m0[i] == (pass == 0)) begin
          it.unp = (pass == 1); it.plane = i; it.cnt = $countones(m0);
          for (int j = 0; j < M; j++) it.word[j] = el[j][i];
          pq.push_back(it);
        end
    prot_mask = m0;
    for (int j = 0; j < M; j++) begin
      in_valid = 1'b1;
      in_elem  = el[j];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (j == 0 && swap_mask) prot_mask = ~m0; // R5: must not affect this group
    end
  endtask

  // Reverse path driver: planes in scrambled order
  task automatic send_planes(input int seed);
    logic [N-1:0] el [M];
    for (int j = 0; j < M; j++) begin
      el[j] = N'($urandom(seed + 5 * j));
      eq.push_back(el[j]);
    end
    for (int k = 0; k < N; k++) begin
      int p;
      p = (k * 7 + 3) % N;
      pin_valid = 1'b1;
      pin_plane = PW'(p);
      for (int j = 0; j < M; j++) pin_word[j] = el[j][p];
      while (!pin_ready) @(negedge clk);
      @(negedge clk);
      pin_valid = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  bit           p_stall = 0, p_unp = 0;
  logic [M-1:0] p_word;
  logic [PW-1:0] p_plane;
  bit           e_stall = 0;
  logic [N-1:0] e_prev;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_stall) begin
        if (p_unp) chk(unp_valid && unp_word == p_word && unp_plane == p_plane,
                       "R7 unp hold", {unp_plane, unp_word}, {p_plane, p_word});
        else       chk(prot_valid && prot_word == p_word && prot_plane == p_plane,
                       "R7 prot hold", {prot_plane, prot_word}, {p_plane, p_word});
      end
      if (e_stall) chk(eout_valid && eout_elem == e_prev, "R10 eout hold", eout_elem, e_prev);
      if (eout_valid) chk(!pin_ready, "R9 pin_ready low while emitting", pin_ready, 0);

      case (rdy_mode)
        0: begin prot_ready = 1; unp_ready = 1; end
        1: begin prot_ready = $urandom % 3 != 0; unp_ready = $urandom % 2 != 0; end
        default: begin prot_ready = 0; unp_ready = 0; end
      endcase
      eout_ready = $urandom % 3 != 0;

      if ((prot_valid && prot_ready) || (unp_valid && unp_ready)) begin
        pitem_t it;
        bit u;
        logic [M-1:0] w;
        int pl;
        u  = unp_valid;
        w  = u ? unp_word : prot_word;
        pl = u ? int'(unp_plane) : int'(prot_plane);
        if (pq.size() == 0) chk(0, "R4 unexpected plane", pl, 0);
        else begin
          it = pq.pop_front();
          chk(u == it.unp, "R3 port", u, it.unp);
          chk(pl == it.plane, "R4 plane order", pl, it.plane);
          chk(w == it.word, "R2 plane bits", w, it.word);
          chk(int'(sel_count) == it.cnt, "R6 sel_count", sel_count, it.cnt);
        end
      end
      p_stall = (prot_valid && !prot_ready) || (unp_valid && !unp_ready);
      p_unp   = unp_valid;
      p_word  = unp_valid ? unp_word : prot_word;
      p_plane = unp_valid ? unp_plane : prot_plane;

      if (eout_valid && eout_ready) begin
        if (eq.size() == 0) chk(0, "R9 unexpected element", eout_elem, 0);
        else begin
          logic [N-1:0] e;
          e = eq.pop_front();
          chk(eout_elem == e, "R9 rebuilt element", eout_elem, e);
        end
      end
      e_stall = eout_valid && !eout_ready;
      e_prev  = eout_elem;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    chk(pin_ready == 1, "R1 pin_ready", pin_ready, 1);
    chk(!prot_valid && !unp_valid, "R1 out valids", {prot_valid, unp_valid}, 0);
    chk(!eout_valid, "R1 eout_valid", eout_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && pin_ready && !prot_valid && !unp_valid && !eout_valid,
        "R1 after reset", {in_ready, pin_ready, prot_valid, unp_valid, eout_valid}, 5'b11000);

    // R8: fill both buffers with consumers stalled
    rdy_mode = 2;
    send_group(16'h7C00, 0, 100);          // half-precision exponent planes
    chk(in_ready == 1, "R8 second buffer free", in_ready, 1);
    send_group(16'h8001, 0, 200);
    chk(in_ready == 0, "R8 stall with two groups", in_ready, 0);
    repeat (4) @(negedge clk);
    chk(in_ready == 0, "R8 stall persists", in_ready, 0);

    // Release with random throttling while next group queues
    rdy_mode = 1;
    send_group(16'h0F0F, 0, 300);
    // Back-to-back streaming, edge masks (none / all selected)
    rdy_mode = 0;
    send_group(16'h0000, 0, 400);
    send_group(16'hFFFF, 0, 500);
    send_group(16'h1234, 0, 600);
    // R5: mask changed after the first element
    rdy_mode = 1;
    send_group(16'h7C00, 1, 700);
    prot_mask = 16'h0000;
    send_group(16'hA5A5, 0, 800);

    // R9: reverse path, two groups
    send_planes(900);
    send_planes(1900);

    while (pq.size() != 0 || eq.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(in_ready == 1, "R8 in_ready after drain", in_ready, 1);
    chk(!prot_valid && !unp_valid, "R4 no extra planes", {prot_valid, unp_valid}, 0);
    chk(!eout_valid && pin_ready, "R9 back to collect", {eout_valid, pin_ready}, 2'b01);
    done = 1;
    summary();
    $finish;
  end
endmodule